// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside a processor core and decides, at each instruction boundary, whether the core enters an interrupt handler and which 8-bit table index it uses. Three sources compete. Internal exceptions carry their own index. An asynchronous non-maskable pin always uses the fixed index 2. A level-sensitive maskable line is honoured only while the interrupt-enable flag is set, and its index is fetched from an external controller through a request/acknowledge handshake.

When an entry is chosen, the block pulses `take_o` for one cycle. That pulse also asks the core to push the flags and the return address. Alongside it the block presents the index, the enable-flag value to be saved, and whether the return address must point back at the faulting instruction. Taking any entry clears the enable flag. An interrupt return reloads the flag from the saved word. While a non-maskable handler runs, every further non-maskable and maskable request is held off until the next interrupt return. One repeat of the non-maskable input that arrives in that window is kept and taken after the return.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `take_o`, `inta_req_o`, `ie_o` and `nmi_busy_o` are all 0.
- R2: An exception present with `insn_bnd_i` while no acknowledge is in progress wins over all other sources. On the next cycle `take_o`=1, `take_vec_o`=`exc_vec_i` and `ret_fault_o`=1.
- R3: A non-maskable entry gives `take_vec_o`=2 and `ret_fault_o`=0, and `inta_req_o` is never raised for it.
- R4: The non-maskable pin is edge detected through a two-flop synchronizer. If the pin goes high before clock edge k and `insn_bnd_i` is held high, `take_o` is 0 after edges k..k+2 and 1 after edge k+3.
- R5: The maskable line is acted on only at a boundary with `ie_o`=1, `nmi_busy_o`=0, no exception and no pending non-maskable event. It then raises `inta_req_o` on the next cycle.
- R6: `inta_req_o` stays high until a cycle with `inta_ack_i`=1. That edge captures `inta_vec_i`, drops `inta_req_o` and gives `take_o`=1 with `take_vec_o`=`inta_vec_i` and `ret_fault_o`=0.
- R7: When a non-maskable event is pending and the maskable line is active at the same boundary, the non-maskable entry is taken and no acknowledge starts.
- R8: Every entry clears `ie_o` on the edge that raises `take_o`. `saved_ie_o` then shows `ie_o` as it was just before.
- R9: `iret_i` loads `ie_o` from `iret_ie_i`. Otherwise `ie_set_i` sets and `ie_clr_i` clears the flag. A concurrent entry overrides both.
- R10: A non-maskable entry sets `nmi_busy_o`. Until an `iret_i` or reset, no non-maskable or maskable entry is started. Exceptions are still taken.
- R11: Rising edges of the pin during service are merged into one pending event. That event is taken at the first boundary after the next `iret_i`, and only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_bnd_i | input | 1 | Core is at an instruction boundary |
| exc_req_i | input | 1 | Internal exception request |
| exc_vec_i | input | 8 | Index supplied by the exception |
| nmi_pin_i | input | 1 | Asynchronous non-maskable request pin |
| intr_lvl_i | input | 1 | Maskable request level |
| inta_req_o | output | 1 | Vector fetch request to external controller |
| inta_ack_i | input | 1 | Controller acknowledge, vector valid |
| inta_vec_i | input | 8 | Vector from external controller |
| ie_set_i | input | 1 | Software sets enable flag |
| ie_clr_i | input | 1 | Software clears enable flag |
| iret_i | input | 1 | Interrupt return executed |
| iret_ie_i | input | 1 | Enable bit of the restored flag word |
| take_o | output | 1 | Entry strobe and push request |
| take_vec_o | output | 8 | Selected table index |
| saved_ie_o | output | 1 | Enable flag value to push |
| ret_fault_o | output | 1 | Return address points at faulting instruction |
| ie_o | output | 1 | Current interrupt-enable flag |
| nmi_busy_o | output | 1 | Non-maskable handler in service |

## Verification
The hardest case to reach is a repeat of the non-maskable input landing inside an active non-maskable handler. The repeat must survive the service window and produce exactly one more entry right after the return, never two. The bench reaches it with directed pin pulses while `nmi_busy_o` is high, followed by a single return. It also runs a long seeded random phase in which pin toggles, returns, boundaries and exceptions overlap freely. That phase is checked cycle by cycle against a bench-side model of the requirements.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } seq_state_t;

  localparam int unsigned VEC_W_DEF   = 8;
  localparam int unsigned NMI_IDX_DEF = 2;
endpackage

// File: rtl/irq_nmi_sync.sv
module irq_nmi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], pin_i};
  end

  // rise seen at the synchronizer output versus one cycle later
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/irq_nmi_track.sv
module irq_nmi_track (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic take_i,
  input  logic iret_i,
  output logic ready_o,
  output logic busy_o
);
  logic pend_q;
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (rise_i)      pend_q <= 1'b1;
      else if (take_i) pend_q <= 1'b0;
      if (take_i)      busy_q <= 1'b1;
      else if (iret_i) busy_q <= 1'b0;
    end
  end

  assign ready_o = pend_q & ~busy_q;
  assign busy_o  = busy_q;

  // R11: a new edge is never lost
  a_r11_edge_kept: assert property (@(posedge clk) disable iff (rst)
    rise_i |=> pend_q);
  // R10: service persists until a return
  a_r10_busy_until_iret: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !iret_i) |=> busy_q);
endmodule

// File: rtl/irq_ie_flag.sv
module irq_ie_flag (
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  input  logic iret_i,
  input  logic restore_i,
  input  logic set_i,
  input  logic clr_i,
  output logic ie_o
);
  logic ie_q;

  always_ff @(posedge clk) begin
    if (rst)         ie_q <= 1'b0;
    else if (take_i) ie_q <= 1'b0;
    else if (iret_i) ie_q <= restore_i;
    else if (set_i)  ie_q <= 1'b1;
    else if (clr_i)  ie_q <= 1'b0;
  end

  assign ie_o = ie_q;

  // R8: entry always leaves the flag cleared
  a_r8_take_clears: assert property (@(posedge clk) disable iff (rst)
    take_i |=> !ie_q);
  // R9: a return without entry reloads the saved bit
  a_r9_iret_restore: assert property (@(posedge clk) disable iff (rst)
    (iret_i && !take_i) |=> (ie_q == $past(restore_i)));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned VEC_W       = VEC_W_DEF,
  parameter int unsigned NMI_IDX     = NMI_IDX_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_bnd_i,
  input  logic             exc_req_i,
  input  logic [VEC_W-1:0] exc_vec_i,
  input  logic             nmi_pin_i,
  input  logic             intr_lvl_i,
  output logic             inta_req_o,
  input  logic             inta_ack_i,
  input  logic [VEC_W-1:0] inta_vec_i,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  input  logic             iret_i,
  input  logic             iret_ie_i,
  output logic             take_o,
  output logic [VEC_W-1:0] take_vec_o,
  output logic             saved_ie_o,
  output logic             ret_fault_o,
  output logic             ie_o,
  output logic             nmi_busy_o
);
  localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NMI_IDX);

  seq_state_t state_q;
  logic nmi_rise, nmi_ready, nmi_busy, ie;
  logic at_idle, go_exc, go_nmi, go_ext, ack_done, take_now;

  irq_nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(nmi_pin_i), .rise_o(nmi_rise)
  );

  irq_nmi_track u_track (
    .clk(clk), .rst(rst), .rise_i(nmi_rise), .take_i(go_nmi),
    .iret_i(iret_i), .ready_o(nmi_ready), .busy_o(nmi_busy)
  );

  irq_ie_flag u_ie (
    .clk(clk), .rst(rst), .take_i(take_now), .iret_i(iret_i),
    .restore_i(iret_ie_i), .set_i(ie_set_i), .clr_i(ie_clr_i), .ie_o(ie)
  );

  // source arbitration: exception, then pending NMI, then maskable
  always_comb begin
    at_idle  = (state_q == ST_IDLE);
    go_exc   = at_idle & insn_bnd_i & exc_req_i;
    go_nmi   = at_idle & insn_bnd_i & ~exc_req_i & nmi_ready;
    go_ext   = at_idle & insn_bnd_i & ~exc_req_i & ~nmi_ready
             & intr_lvl_i & ie & ~nmi_busy;
    ack_done = (state_q == ST_ACK) & inta_ack_i;
    take_now = go_exc | go_nmi | ack_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      take_o      <= 1'b0;
      take_vec_o  <= '0;
      saved_ie_o  <= 1'b0;
      ret_fault_o <= 1'b0;
    end else begin
      if (go_ext)        state_q <= ST_ACK;
      else if (ack_done) state_q <= ST_IDLE;
      take_o <= take_now;
      if (take_now) begin
        saved_ie_o  <= ie;
        ret_fault_o <= go_exc;
        if (go_exc)      take_vec_o <= exc_vec_i;
        else if (go_nmi) take_vec_o <= NMI_VEC;
        else             take_vec_o <= inta_vec_i;
      end
    end
  end

  assign inta_req_o = (state_q == ST_ACK);
  assign ie_o       = ie;
  assign nmi_busy_o = nmi_busy;

  // R3: entering NMI service coincides with an index-2 entry
  a_r3_nmi_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_busy) |-> (take_o && take_vec_o == NMI_VEC && !ret_fault_o));
  // R6: the fetch request waits for its acknowledge
  a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
    (inta_req_o && !inta_ack_i) |=> inta_req_o);
  // R5: a fetch starts only with the flag set and no NMI service
  a_r5_req_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(inta_req_o) |-> ($past(ie) && !$past(nmi_busy)));
  // R10: during service only exceptions enter
  a_r10_only_exc: assert property (@(posedge clk) disable iff (rst)
    (take_now && nmi_busy) |-> go_exc);
  // R8: an entry strobe sees the flag already cleared
  a_r8_strobe_flag: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !ie_o);
endmodule

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bnd = 0, exc = 0, nmi = 0, intr = 0, ack = 0;
  logic sti = 0, cli = 0, iret = 0, rest = 0;
  logic [7:0] exc_vec = 0, ack_vec = 0;
  logic req, take, sie, fault, ie, busy;
  logic [7:0] vec;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic m_s1, m_s2, m_s3, m_pend, m_busy, m_ie, m_ack, m_take, m_pie, m_fault;
  logic [7:0] m_vec;
  int m_src;

  always #2.5 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst(rst), .insn_bnd_i(bnd), .exc_req_i(exc), .exc_vec_i(exc_vec),
    .nmi_pin_i(nmi), .intr_lvl_i(intr), .inta_req_o(req), .inta_ack_i(ack),
    .inta_vec_i(ack_vec), .ie_set_i(sti), .ie_clr_i(cli), .iret_i(iret),
    .iret_ie_i(rest), .take_o(take), .take_vec_o(vec), .saved_ie_o(sie),
    .ret_fault_o(fault), .ie_o(ie), .nmi_busy_o(busy)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_s1, m_s2, m_s3, m_pend, m_busy, m_ie, m_ack, m_take, m_pie, m_fault} = '0;
    m_vec = 0; m_src = 0;
  endtask

  task automatic model_step();
    logic edge_s, ready, g_exc, g_nmi, g_ext, g_ack, tk;
    edge_s = m_s2 & ~m_s3;
    ready  = m_pend & ~m_busy;
    g_exc  = !m_ack && bnd && exc;
    g_nmi  = !m_ack && bnd && !exc && ready;
    g_ext  = !m_ack && bnd && !exc && !ready && intr && m_ie && !m_busy;
    g_ack  = m_ack && ack;
    tk     = g_exc | g_nmi | g_ack;
    m_take = tk;
    if (tk) begin
      m_pie   = m_ie;
      m_fault = g_exc;
      m_vec   = g_exc ? exc_vec : (g_nmi ? 8'd2 : ack_vec);
      m_src   = g_exc ? 2 : (g_nmi ? 3 : 6);
    end
    if (tk)        m_ie = 1'b0;
    else if (iret) m_ie = rest;
    else if (sti)  m_ie = 1'b1;
    else if (cli)  m_ie = 1'b0;
    if (g_nmi)     m_busy = 1'b1;
    else if (iret) m_busy = 1'b0;
    if (edge_s)     m_pend = 1'b1;
    else if (g_nmi) m_pend = 1'b0;
    if (g_ext)      m_ack = 1'b1;
    else if (g_ack) m_ack = 1'b0;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = nmi;
  endtask

  task automatic compare();
    check("R2/R3/R6 take", take, m_take);
    if (m_take) begin
      check($sformatf("R%0d vector", m_src), vec, m_vec);
      check("R8 saved flag", sie, m_pie);
      check("R2 fault address", fault, m_fault);
    end
    check("R5 fetch request", req, m_ack);
    check("R9 enable flag", ie, m_ie);
    check("R10 service state", busy, m_busy);
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic clear_in();
    bnd = 0; exc = 0; intr = 0; ack = 0; sti = 0; cli = 0; iret = 0; rest = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 take in reset", take, 0);
    check("R1 req in reset", req, 0);
    check("R1 flag in reset", ie, 0);
    check("R1 busy in reset", busy, 0);
    rst = 0;
    step();
    check("R1 take after reset", take, 0);

    // exception entry with flag set (R2, R8)
    sti = 1; step(); sti = 0;
    bnd = 1; exc = 1; exc_vec = 8'd0; intr = 1; step();
    check("R2 exception vector", vec, 0);
    check("R2 fault flag", fault, 1);
    check("R8 saved before clear", sie, 1);
    check("R8 flag cleared", ie, 0);
    clear_in();

    // NMI edge latency (R4, R3)
    bnd = 1; nmi = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R4 no early entry", take, 0);
    end
    step();
    check("R4 entry on fourth edge", take, 1);
    check("R3 fixed vector", vec, 2);
    check("R3 no fetch", req, 0);
    nmi = 0;

    // repeats during service merge and wait for return (R10, R11)
    sti = 1; step(); sti = 0; intr = 1;
    for (int p = 0; p < 2; p++) begin
      nmi = 1; step(); step();
      nmi = 0; step(); step();
    end
    repeat (3) step();
    check("R10 blocked entry", take, 0);
    check("R10 blocked fetch", req, 0);
    intr = 0; iret = 1; rest = 0; step(); iret = 0;
    step();
    check("R11 repeat taken after return", take, 1);
    check("R11 repeat vector", vec, 2);
    iret = 1; step(); iret = 0;
    repeat (6) begin
      step();
      check("R11 merged, single repeat", take, 0);
    end

    // NMI beats maskable (R7)
    bnd = 0; sti = 1; step(); sti = 0;
    intr = 1; nmi = 1; repeat (4) step();
    bnd = 1; step();
    check("R7 NMI wins", vec, 2);
    check("R7 no fetch", req, 0);
    clear_in(); nmi = 0;
    iret = 1; rest = 1; step(); clear_in();
    step();

    // maskable handshake (R5, R6)
    intr = 1; bnd = 1; step();
    check("R5 fetch raised", req, 1);
    check("R5 no strobe yet", take, 0);
    clear_in(); step(); step();
    check("R6 request held", req, 1);
    ack = 1; ack_vec = 8'h47; step(); ack = 0;
    check("R6 fetched vector", vec, 8'h47);
    check("R6 request dropped", req, 0);
    check("R6 not fault", fault, 0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      bnd     = ($urandom % 10) < 6;
      exc     = ($urandom % 10) == 0;
      exc_vec = 8'($urandom % 32);
      intr    = ($urandom % 3) == 0;
      ack     = req && (($urandom % 3) == 0);
      ack_vec = 8'(32 + ($urandom % 224));
      if (($urandom % 8) == 0) nmi = ~nmi;
      iret    = ($urandom % 12) == 0;
      rest    = $urandom % 2;
      sti     = ($urandom % 6) == 0;
      cli     = !sti && (($urandom % 15) == 0);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule